// File: doc/BRIEF.md
# Watchdog Timer with Selectable Source and Prescaler

This block guards a processor against runaway software. It counts ticks from one of three count sources: an on-chip RC oscillator tick, a 32768 Hz crystal tick, or the instruction clock, which is the system clock divided by four. The count passes through a fixed 9-stage divider. A prescaler follows it, and its length is set by a 3-bit select input. If software does not clear the block before the chosen period runs out, the block raises a one-cycle timeout pulse, which the system reset logic consumes.

The oscillator ticks reach the block as enables that are already synchronized to the system clock, so every register sits in one clock domain. The source select and the period select are meant to be held static. A build parameter can remove the watchdog entirely. In that case the timeout output is held low and the clear input has no effect.

Top module: `wdog_core`

## Requirements
- R1: A synchronous active-high reset holds `timeout_o` low and zeroes both counting stages. Counting starts with the first clock edge at which reset is sampled low.
- R2: `src_sel_i` picks the count source: 2'b00 selects `rc_tick_i`, 2'b01 selects `xtal_tick_i`, and 2'b10 or 2'b11 selects the internal instruction tick. Ticks on a source that is not selected have no effect.
- R3: The instruction tick runs free from reset, is high one clock in four, and is first counted at the 4th clock edge after reset release.
- R4: The timeout period equals 512 x 2^`wsel_i` counted ticks of the selected source, for `wsel_i` from 0 to 7.
- R5: A high `clr_i` sampled at a clock edge zeroes both the fixed divider and the prescaler. A tick that arrives in the same cycle as the clear is not counted.
- R6: The timeout is a registered single-cycle pulse. It is high in the cycle after the edge that counts the final tick. Counting then restarts from zero, so the next pulse follows one full period later.
- R7: When a clear lands on the same edge as the final tick of a period, the clear takes precedence: no pulse is issued and a new full period begins.
- R8: With the build parameter `WDOG_EN` = 0, `timeout_o` never rises and `clr_i` and every other input have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| src_sel_i | input | 2 | Count source select (static) |
| wsel_i | input | 3 | Prescaler length select, period 512 x 2^value ticks |
| rc_tick_i | input | 1 | RC oscillator tick enable, synchronous to clk |
| xtal_tick_i | input | 1 | Crystal tick enable, synchronous to clk |
| clr_i | input | 1 | Software clear of the watchdog count |
| timeout_o | output | 1 | One-cycle timeout pulse toward reset logic |

## Verification
Two functions can fall in the same cycle. A software clear can coincide with the tick that would complete a period, and a clear can coincide with an ordinary tick. To provoke the first case, the bench times a clear onto the exact edge that counts the 512th tick. It then expects no pulse at that edge and exactly one pulse a full period after the clear. The second case is judged in every run, because the RC tick is high on the clear edge itself. A pulse one edge early would show that the tick was wrongly counted.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  typedef enum logic [1:0] {
    SRC_RC   = 2'b00,
    SRC_XTAL = 2'b01,
    SRC_INST = 2'b10
  } wd_src_e;

endpackage

// File: rtl/wdog_src_sel.sv
module wdog_src_sel
  import wdog_pkg::*;
#(
  parameter int IDIV_W = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] src_sel_i,
  input  logic       rc_tick_i,
  input  logic       xtal_tick_i,
  output logic       cnt_en_o
);

  // free-running instruction clock divider (2^IDIV_W system clocks)
  logic [IDIV_W-1:0] icnt_q;
  logic              inst_tick;

  always_ff @(posedge clk) begin
    if (rst) icnt_q <= '0;
    else     icnt_q <= icnt_q + 1'b1;
  end

  assign inst_tick = &icnt_q;

  always_comb begin
    case (src_sel_i)
      SRC_RC:   cnt_en_o = rc_tick_i;
      SRC_XTAL: cnt_en_o = xtal_tick_i;
      default:  cnt_en_o = inst_tick;
    endcase
  end

  // R3: instruction tick never lasts two consecutive cycles
  assert_inst_tick_single_R3: assert property (@(posedge clk) disable iff (rst)
    inst_tick |=> !inst_tick);

endmodule

// File: rtl/wdog_fixdiv.sv
module wdog_fixdiv #(
  parameter int STAGES = 9
) (
  input  logic clk,
  input  logic rst,
  input  logic clr_i,
  input  logic en_i,
  output logic carry_o
);

  logic [STAGES-1:0] div_q;

  always_ff @(posedge clk) begin
    if (rst || clr_i) div_q <= '0;
    else if (en_i)    div_q <= div_q + 1'b1;
  end

  // wrap of the fixed stage; a clear suppresses it
  assign carry_o = en_i & (&div_q) & ~clr_i;

  assert_clear_zeroes_div_R5: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (div_q == '0));

  assert_hold_without_tick_R2: assert property (@(posedge clk) disable iff (rst)
    (!en_i && !clr_i) |=> $stable(div_q));

endmodule

// File: rtl/wdog_presc.sv
module wdog_presc #(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_i,
  input  logic             step_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             expire_o
);

  localparam int PRE_W = (1 << SEL_W) - 1;

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] mask;

  // low sel_i bits of the prescaler must be all ones for expiry
  always_comb begin
    for (int i = 0; i < PRE_W; i++) begin
      mask[i] = (int'(sel_i) > i);
    end
  end

  assign expire_o = step_i & ((pre_q & mask) == mask);

  always_ff @(posedge clk) begin
    if (rst || clr_i)  pre_q <= '0;
    else if (expire_o) pre_q <= '0;
    else if (step_i)   pre_q <= pre_q + 1'b1;
  end

  assert_restart_after_expiry_R6: assert property (@(posedge clk) disable iff (rst)
    expire_o |=> (pre_q == '0));

  assert_clear_zeroes_pre_R5: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (pre_q == '0));

endmodule

// File: rtl/wdog_core.sv
module wdog_core #(
  parameter bit WDOG_EN    = 1'b1,
  parameter int FIX_STAGES = 9,
  parameter int SEL_W      = 3,
  parameter int IDIV_W     = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       src_sel_i,
  input  logic [SEL_W-1:0] wsel_i,
  input  logic             rc_tick_i,
  input  logic             xtal_tick_i,
  input  logic             clr_i,
  output logic             timeout_o
);

  generate
    if (WDOG_EN) begin : g_on
      logic cnt_en;
      logic carry;
      logic expire;
      logic timeout_q;

      wdog_src_sel #(.IDIV_W(IDIV_W)) u_src (
        .clk         (clk),
        .rst         (rst),
        .src_sel_i   (src_sel_i),
        .rc_tick_i   (rc_tick_i),
        .xtal_tick_i (xtal_tick_i),
        .cnt_en_o    (cnt_en)
      );

      wdog_fixdiv #(.STAGES(FIX_STAGES)) u_div (
        .clk     (clk),
        .rst     (rst),
        .clr_i   (clr_i),
        .en_i    (cnt_en),
        .carry_o (carry)
      );

      wdog_presc #(.SEL_W(SEL_W)) u_pre (
        .clk      (clk),
        .rst      (rst),
        .clr_i    (clr_i),
        .step_i   (carry),
        .sel_i    (wsel_i),
        .expire_o (expire)
      );

      always_ff @(posedge clk) begin
        if (rst) timeout_q <= 1'b0;
        else     timeout_q <= expire;
      end

      assign timeout_o = timeout_q;

      assert_single_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        timeout_o |=> !timeout_o);

      assert_clear_beats_expiry_R7: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> !timeout_o);

      assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> !timeout_o);
    end else begin : g_off
      // R8: watchdog removed; inputs are sunk and the output is held low
      logic unused_inputs;
      assign unused_inputs = ^{clk, rst, src_sel_i, wsel_i, rc_tick_i, xtal_tick_i, clr_i};
      assign timeout_o     = 1'b0;
    end
  endgenerate

endmodule

// File: tb/wdog_core_tb_top.sv
`timescale 1ns/1ps
module wdog_core_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] src = 2'b00;
  logic [2:0] ws  = 3'd0;
  logic       rc_tick = 1'b1;
  logic       xtal_tick = 1'b0;
  logic       clr = 1'b0;
  logic       to_on;
  logic       to_off;

  int cyc = 0;
  int n_chk = 0;
  int n_bad = 0;
  int off_pulses = 0;
  int exp_q[$];
  string tag_q[$];
  bit done = 1'b0;

  always #2 clk = ~clk;

  wdog_core dut_i (
    .clk(clk), .rst(rst), .src_sel_i(src), .wsel_i(ws),
    .rc_tick_i(rc_tick), .xtal_tick_i(xtal_tick), .clr_i(clr), .timeout_o(to_on)
  );

  wdog_core #(.WDOG_EN(1'b0)) dut_off_i (
    .clk(clk), .rst(rst), .src_sel_i(src), .wsel_i(ws),
    .rc_tick_i(rc_tick), .xtal_tick_i(xtal_tick), .clr_i(clr), .timeout_o(to_off)
  );

  // edge index since reset release
  always @(posedge clk) begin
    if (rst) cyc <= 0;
    else     cyc <= cyc + 1;
  end

  // crystal tick on edges that are multiples of 3
  always @(negedge clk) xtal_tick <= ((cyc + 1) % 3 == 0);

  // monitor: pops expected pulse edges and compares
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (exp_q.size() != 0 && cyc > exp_q[0]) begin
        n_chk++; n_bad++;
        $display("FAIL %s: no pulse, actual none by edge %0d, expected edge %0d",
                 tag_q[0], cyc, exp_q[0]);
        void'(exp_q.pop_front()); void'(tag_q.pop_front());
      end
      if (to_on) begin
        n_chk++;
        if (exp_q.size() == 0) begin
          n_bad++;
          $display("FAIL R7: pulse at edge %0d, expected none", cyc);
        end else begin
          int e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          if (cyc != e) begin
            n_bad++;
            $display("FAIL %s: pulse at edge %0d, expected edge %0d", t, cyc, e);
          end
        end
      end
      if (to_off) off_pulses++;
    end
  end

  function automatic int nth_edge(int c, int p, int n);
    return (c / p + 1) * p + (n - 1) * p;
  endfunction

  // called at a negedge; clear lands on the next edge
  task automatic do_clear(output int c);
    clr = 1'b1;
    c = cyc + 1;
    @(negedge clk);
    clr = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic run_case(input logic [1:0] s, input logic [2:0] w, input int p,
                          input string tag, input int periods);
    int c;
    int e;
    int n;
    src = s; ws = w;
    n = 512 << w;
    do_clear(c);
    e = c;
    for (int k = 0; k < periods; k++) begin
      e = nth_edge(e, p, n);
      exp_q.push_back(e);
      tag_q.push_back(tag);
    end
    drain();
  endtask

  initial begin
    int c1;
    int c2;
    // R1: quiet during reset, first pulse 512 ticks after release
    repeat (3) @(negedge clk);
    n_chk++;
    if (to_on !== 1'b0 || to_off !== 1'b0) begin
      n_bad++;
      $display("FAIL R1: timeout during reset actual %b/%b expected 0/0", to_on, to_off);
    end
    exp_q.push_back(512); tag_q.push_back("R1");
    rst = 1'b0;
    drain();

    // R4, R6: RC source, several lengths, with automatic restart
    run_case(2'b00, 3'd0, 1, "R6", 2);
    run_case(2'b00, 3'd1, 1, "R4", 1);
    run_case(2'b00, 3'd2, 1, "R4", 1);
    run_case(2'b00, 3'd3, 1, "R4", 1);
    // R2: crystal selected while RC ticks every cycle
    run_case(2'b01, 3'd0, 3, "R2", 1);
    run_case(2'b01, 3'd1, 3, "R2", 1);
    // R3: instruction tick via both encodings
    run_case(2'b10, 3'd0, 4, "R3", 1);
    run_case(2'b10, 3'd1, 4, "R3", 1);
    run_case(2'b11, 3'd0, 4, "R3", 1);

    // R5: clear part way restarts the full period
    src = 2'b00; ws = 3'd0;
    do_clear(c1);
    repeat (300) @(negedge clk);
    do_clear(c2);
    exp_q.push_back(c2 + 512); tag_q.push_back("R5");
    drain();

    // R7: clear on the very edge of the final tick
    do_clear(c1);
    while (cyc != c1 + 511) @(negedge clk);
    do_clear(c2);
    exp_q.push_back(c2 + 512); tag_q.push_back("R7");
    drain();

    // R8: disabled build never pulses
    n_chk++;
    if (off_pulses != 0) begin
      n_bad++;
      $display("FAIL R8: disabled pulses actual %0d expected 0", off_pulses);
    end
    n_chk++;
    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL R6: pending pulses actual %0d expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: run hung, actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule